// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital half of a 16-bit successive-approximation converter. It watches a convert command and a free-running conversion clock, steps a trial word through an external DAC, reads back a one-bit comparator decision each step, and builds the digital code one bit at a time from the most significant bit down. While the convert command is high the sequencer rests in halt. The low-going edge of the command arms a conversion frame of 17 conversion-clock pulses.

The block gates the conversion clock onto its own clock output for exactly those 17 pulses. It raises a busy status flag for the length of the frame and streams each bit decision on a serial pin as soon as it is made. An active-low short-cycle input cuts a frame short at a falling conversion-clock edge, leaving only the bits already decided. The finished code is presented as straight offset binary or as two's complement, and a separate pin carries the inverted MSB of the live trial word.

The conversion clock is treated as a level input sampled by the system clock, so every result is produced by synchronous logic.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, status, gated clock, serial output, trial word and raw result are all zero (so the offset-binary code reads 0000 and the inverted MSB pin reads 1). The sequencer then waits for the convert command to go high and then low before any conversion.
- R2: While the convert command is high, no gated clock pulse is produced, status stays low and the trial word is held at zero, whatever the conversion clock does.
- R3: A conversion starts when the convert command goes low. From the first conversion-clock rising edge after that, exactly 17 clock pulses are passed to the gated clock output, and none are passed after the 17th.
- R4: Status goes high together with the first gated pulse, stays high through gated pulses 1 to 16, and is low from the 17th gated rising edge on.
- R5: At gated rising edges 2 to 17, the serial output presents the decisions for bits 15 down to 0, in that order (MSB first).
- R6: On gated pulse 1, trial bit 15 is set. At each later rising edge, the pending bit is kept if the comparator input (1 = analog input at or above the DAC level) is high and cleared if it is low, and the next lower bit is set. The raw result after a full frame equals the largest trial word not above the analog level.
- R7: The code output equals the raw result when the code select input is low. When it is high, the output is the raw result with bit 15 inverted (two's complement). Examples: raw FFFF gives 7FFF, raw 0000 gives 8000, raw 8000 gives 0000, raw 7FFF gives FFFF.
- R8: The inverted-MSB output always equals the complement of bit 15 of the current trial word.
- R9: If short-cycle is low at a falling conversion-clock edge during gated pulse k (k from 1 to 16), the frame stops there after k gated pulses. The raw result keeps the k−1 decided bits and holds zero in the pending bit and in every untried bit.
- R10: After a short-cycle stop, status follows the short-cycle input one system clock later, including going high when short-cycle returns high.
- R11: A high level on the convert command during a frame aborts it. Status is low one system clock later and no further gated pulses occur.
- R12: After a short-cycle stop, further conversion-clock pulses produce no gated pulses and leave the code unchanged until the convert command goes high and then low again. The next frame then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convert_i | input | 1 | Convert command; high = halt, low-going edge starts a frame |
| cclk_i | input | 1 | Conversion clock, sampled as a level |
| cmp_ge_i | input | 1 | Comparator decision: 1 when the analog input is at or above the DAC level |
| short_n_i | input | 1 | Active-low short-cycle request |
| twos_sel_i | input | 1 | Code select: 1 = two's complement, 0 = offset binary |
| trial_o | output | 16 | Trial word driving the external DAC |
| status_o | output | 1 | Busy status flag |
| gclk_o | output | 1 | Gated conversion clock (17 pulses per frame) |
| ser_o | output | 1 | Real-time serial bit decision |
| msb_n_o | output | 1 | Inverted MSB of the trial word |
| code_o | output | 16 | Final code in the selected coding |

## Verification
One register stands between any conversion-clock edge and the outputs. The gated clock, status, serial bit and trial word therefore all change on the system edge that first samples the new conversion-clock level. The bench drives every input on the falling system edge and reads outputs on the next falling edge, half a cycle after that update. The code output follows the select input with no register, so it is read one cycle after the select changes. Status after a short-cycle stop, and after an abort, is read one full system cycle after the input that causes it.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    S_HALT  = 3'd0,
    S_ARMED = 3'd1,
    S_RUN   = 3'd2,
    S_DONE  = 3'd3,
    S_CUT   = 3'd4
  } seq_state_t;

endpackage

// File: rtl/sar_clk_edges.sv
module sar_clk_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cclk_i,
  output logic rise_o,
  output logic fall_o
);

  logic cclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cclk_q <= 1'b0;
    else        cclk_q <= cclk_i;
  end

  assign rise_o = cclk_i & ~cclk_q;
  assign fall_o = ~cclk_i & cclk_q;

endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic convert_i,
  input  logic short_n_i,
  input  logic cclk_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic status_o,
  output logic gclk_o,
  output logic ev_clear_o,
  output logic ev_first_o,
  output logic ev_step_o,
  output logic ev_cut_o
);

  localparam int PULSES = NBITS + 1;
  localparam int CW     = $clog2(PULSES + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSES);

  seq_state_t state_q, state_d;
  logic [CW-1:0] pcnt_q, pcnt_d;
  logic status_q, status_d;
  logic gclk_q;
  logic frame_end_w, cut_req_w;

  assign frame_end_w = fall_i && (pcnt_q == LAST);
  assign cut_req_w   = fall_i && (pcnt_q != LAST) && !short_n_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_HALT:  if (!convert_i) state_d = S_ARMED;
      S_ARMED: begin
        if (convert_i)   state_d = S_HALT;
        else if (rise_i) state_d = S_RUN;
      end
      S_RUN: begin
        if (convert_i)        state_d = S_HALT;
        else if (frame_end_w) state_d = S_DONE;
        else if (cut_req_w)   state_d = S_CUT;
      end
      S_DONE, S_CUT: if (convert_i) state_d = S_HALT;
      default: state_d = S_HALT;
    endcase
  end

  always_comb begin
    pcnt_d = pcnt_q;
    if (state_d == S_HALT || state_d == S_ARMED) pcnt_d = '0;
    else if (rise_i && (state_q == S_ARMED || state_q == S_RUN) && state_d == S_RUN)
      pcnt_d = pcnt_q + 1'b1;
  end

  always_comb begin
    status_d = status_q;
    if (state_d == S_HALT)                                    status_d = 1'b0;
    else if (state_q == S_ARMED && state_d == S_RUN)          status_d = 1'b1;
    else if (state_q == S_RUN && state_d == S_RUN && rise_i && pcnt_d == LAST)
                                                              status_d = 1'b0;
    else if (state_d == S_CUT)                                status_d = short_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_DONE;
      pcnt_q   <= '0;
      status_q <= 1'b0;
      gclk_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pcnt_q   <= pcnt_d;
      status_q <= status_d;
      gclk_q   <= (state_d == S_RUN) && cclk_i;
    end
  end

  assign ev_clear_o = (state_d == S_HALT);
  assign ev_first_o = (state_q == S_ARMED) && (state_d == S_RUN);
  assign ev_step_o  = (state_q == S_RUN) && (state_d == S_RUN) && rise_i;
  assign ev_cut_o   = (state_q == S_RUN) && (state_d == S_CUT);
  assign status_o   = status_q;
  assign gclk_o     = gclk_q;

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HALT) |-> (!status_q && !gclk_q)); // R2

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= LAST); // R3

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ARMED && rise_i && !convert_i) |=> status_q); // R4

  AST_CUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CUT) |-> !gclk_q); // R9

  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_ARMED || state_q == S_RUN) && convert_i) |=> (state_q == S_HALT && !status_q)); // R11

  AST_CUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CUT && !convert_i) |=> (state_q == S_CUT)); // R12

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_clear_i,
  input  logic             ev_first_i,
  input  logic             ev_step_i,
  input  logic             ev_cut_i,
  input  logic             cmp_ge_i,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] raw_o,
  output logic             ser_o
);

  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] trial_q, ptr_q, raw_q;
  logic             ser_q;
  logic [NBITS-1:0] decided_w, next_ptr_w, cut_word_w;

  function automatic logic [NBITS-1:0] settle_bit(
    input logic [NBITS-1:0] word,
    input logic [NBITS-1:0] pend,
    input logic             keep
  );
    return keep ? word : (word & ~pend);
  endfunction

  assign decided_w  = settle_bit(trial_q, ptr_q, cmp_ge_i);
  assign next_ptr_w = ptr_q >> 1;
  assign cut_word_w = settle_bit(trial_q, ptr_q, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      ptr_q   <= '0;
      raw_q   <= '0;
      ser_q   <= 1'b0;
    end else if (ev_clear_i) begin
      trial_q <= '0;
      ptr_q   <= '0;
      ser_q   <= 1'b0;
    end else if (ev_first_i) begin
      trial_q <= TOP_BIT;
      ptr_q   <= TOP_BIT;
      ser_q   <= 1'b0;
    end else if (ev_step_i) begin
      trial_q <= decided_w | next_ptr_w;
      ptr_q   <= next_ptr_w;
      ser_q   <= cmp_ge_i;
      if (ptr_q[0]) raw_q <= decided_w;
    end else if (ev_cut_i) begin
      trial_q <= cut_word_w;
      ptr_q   <= '0;
      raw_q   <= cut_word_w;
    end
  end

  assign trial_o = trial_q;
  assign raw_o   = raw_q;
  assign ser_o   = ser_q;

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q)); // R6

  AST_CUT_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cut_i |=> (ptr_q == '0)); // R9

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convert_i,
  input  logic             cclk_i,
  input  logic             cmp_ge_i,
  input  logic             short_n_i,
  input  logic             twos_sel_i,
  output logic [NBITS-1:0] trial_o,
  output logic             status_o,
  output logic             gclk_o,
  output logic             ser_o,
  output logic             msb_n_o,
  output logic [NBITS-1:0] code_o
);

  logic cclk_rise_w, cclk_fall_w;
  logic ev_clear_w, ev_first_w, ev_step_w, ev_cut_w;
  logic [NBITS-1:0] raw_w;

  function automatic logic [NBITS-1:0] encode_out(
    input logic [NBITS-1:0] raw,
    input logic             twos
  );
    return twos ? {~raw[NBITS-1], raw[NBITS-2:0]} : raw;
  endfunction

  sar_clk_edges u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .cclk_i (cclk_i),
    .rise_o (cclk_rise_w),
    .fall_o (cclk_fall_w)
  );

  sar_frame_ctl #(.NBITS(NBITS)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .convert_i  (convert_i),
    .short_n_i  (short_n_i),
    .cclk_i     (cclk_i),
    .rise_i     (cclk_rise_w),
    .fall_i     (cclk_fall_w),
    .status_o   (status_o),
    .gclk_o     (gclk_o),
    .ev_clear_o (ev_clear_w),
    .ev_first_o (ev_first_w),
    .ev_step_o  (ev_step_w),
    .ev_cut_o   (ev_cut_w)
  );

  sar_bit_engine #(.NBITS(NBITS)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_clear_i (ev_clear_w),
    .ev_first_i (ev_first_w),
    .ev_step_i  (ev_step_w),
    .ev_cut_i   (ev_cut_w),
    .cmp_ge_i   (cmp_ge_i),
    .trial_o    (trial_o),
    .raw_o      (raw_w),
    .ser_o      (ser_o)
  );

  assign msb_n_o = ~trial_o[NBITS-1];
  assign code_o  = encode_out(raw_w, twos_sel_i);

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_clear_w, ev_first_w, ev_step_w, ev_cut_w})); // R6

  AST_NO_GCLK_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(convert_i) && convert_i) |-> !gclk_o); // R2

endmodule

// File: tb/sar_conv_seq_tb.sv
`timescale 1ns/1ps
module sar_conv_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convert = 1'b1;
  logic cclk = 1'b0;
  logic short_n = 1'b1;
  logic twos_sel = 1'b0;
  logic [15:0] analog = 16'h0000;
  logic cmp_ge;
  logic [15:0] trial_o, code_o;
  logic status_o, gclk_o, ser_o, msb_n_o;

  int n_chk = 0;
  int n_fail = 0;
  int rises = 0;
  logic [15:0] ser_word = '0;
  logic [16:0] st_seen = '0;
  logic gprev = 1'b0;

  always #4 clk = ~clk;

  assign cmp_ge = (analog >= trial_o);

  sar_conv_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .convert_i  (convert),
    .cclk_i     (cclk),
    .cmp_ge_i   (cmp_ge),
    .short_n_i  (short_n),
    .twos_sel_i (twos_sel),
    .trial_o    (trial_o),
    .status_o   (status_o),
    .gclk_o     (gclk_o),
    .ser_o      (ser_o),
    .msb_n_o    (msb_n_o),
    .code_o     (code_o)
  );

  always @(negedge clk) begin
    if (gclk_o && !gprev) begin
      rises = rises + 1;
      if (rises >= 2 && rises <= 17) ser_word = {ser_word[14:0], ser_o};
      if (rises <= 17) st_seen[rises-1] = status_o;
    end
    gprev = gclk_o;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse();
    cclk = 1'b1;
    repeat (3) tick();
    cclk = 1'b0;
    repeat (3) tick();
  endtask

  task automatic clear_mon();
    rises = 0;
    ser_word = '0;
    st_seen = '0;
  endtask

  function automatic logic [15:0] expect_code(input logic [15:0] raw, input logic twos);
    return twos ? raw + 16'h8000 : raw;
  endfunction

  task automatic test_reset();
    check(status_o == 1'b0, "R1 status", status_o, 0);
    check(gclk_o == 1'b0, "R1 gclk", gclk_o, 0);
    check(ser_o == 1'b0, "R1 serial", ser_o, 0);
    check(trial_o == 16'h0, "R1 trial", trial_o, 0);
    check(code_o == 16'h0, "R1 code", code_o, 0);
    check(msb_n_o == 1'b1, "R1 msb_n", msb_n_o, 1);
  endtask

  task automatic test_halt();
    convert = 1'b1;
    repeat (2) tick();
    clear_mon();
    pulse();
    pulse();
    check(rises == 0, "R2 no pulses in halt", rises, 0);
    check(status_o == 1'b0, "R2 status in halt", status_o, 0);
    check(trial_o == 16'h0, "R2 trial in halt", trial_o, 0);
    check(msb_n_o == 1'b1, "R8 msb_n in halt", msb_n_o, 1);
  endtask

  task automatic run_conv(input logic [15:0] vin, input logic twos, input int cut_at, input int npulse);
    logic [15:0] raw_exp;
    int exp_r;
    analog = vin;
    twos_sel = twos;
    short_n = 1'b1;
    convert = 1'b1;
    repeat (3) tick();
    check(status_o == 1'b0, "R2 status while command high", status_o, 0);
    clear_mon();
    convert = 1'b0;
    repeat (2) tick();
    for (int p = 1; p <= npulse; p++) begin
      if (p == cut_at) short_n = 1'b0;
      if (p == 2) begin
        cclk = 1'b1;
        tick();
        check(msb_n_o == ~trial_o[15], "R8 msb_n mid frame", msb_n_o, ~trial_o[15]);
        repeat (2) tick();
        cclk = 1'b0;
        repeat (3) tick();
      end else begin
        pulse();
      end
    end
    repeat (2) tick();
    exp_r = (cut_at > 0) ? cut_at : 17;
    raw_exp = (cut_at > 0) ? (vin & 16'(32'hFFFF << (17 - cut_at))) : vin;
    check(rises == exp_r, (cut_at > 0) ? "R9 R12 pulse count after cut" : "R3 pulse count", rises, exp_r);
    check(code_o == expect_code(raw_exp, twos), (cut_at > 0) ? "R9 short result" : (twos ? "R7 twos code" : "R6 offset code"),
          code_o, expect_code(raw_exp, twos));
    if (cut_at == 0) begin
      check(ser_word == vin, "R5 serial stream", ser_word, vin);
      check(st_seen == 17'h0FFFF, "R4 status per pulse", st_seen, 17'h0FFFF);
      check(status_o == 1'b0, "R4 status after frame", status_o, 0);
      check(msb_n_o == ~vin[15], "R8 msb_n final", msb_n_o, ~vin[15]);
    end else begin
      if (cut_at >= 2)
        check(16'(ser_word << (17 - cut_at)) == raw_exp, "R5 R9 serial before cut", ser_word, raw_exp);
      check(status_o == 1'b0, "R10 status with short low", status_o, 0);
      short_n = 1'b1;
      tick();
      check(status_o == 1'b1, "R10 status follows short high", status_o, 1);
      pulse();
      check(rises == exp_r, "R12 stays stopped", rises, exp_r);
      check(code_o == expect_code(raw_exp, twos), "R12 code held", code_o, expect_code(raw_exp, twos));
    end
  endtask

  task automatic test_abort();
    analog = 16'h6A6A;
    twos_sel = 1'b0;
    convert = 1'b1;
    repeat (3) tick();
    clear_mon();
    convert = 1'b0;
    repeat (2) tick();
    for (int p = 1; p <= 5; p++) pulse();
    check(status_o == 1'b1, "R4 status mid frame", status_o, 1);
    convert = 1'b1;
    tick();
    check(status_o == 1'b0, "R11 status after abort", status_o, 0);
    pulse();
    pulse();
    check(rises == 5, "R11 no pulses after abort", rises, 5);
  endtask

  task automatic test_select_flip();
    twos_sel = 1'b1;
    tick();
    check(code_o == expect_code(16'h0001, 1'b1), "R7 select flip", code_o, expect_code(16'h0001, 1'b1));
    twos_sel = 1'b0;
    tick();
    check(code_o == 16'h0001, "R7 select back", code_o, 16'h0001);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    test_reset();
    test_halt();
    run_conv(16'hA5C3, 1'b0, 0, 19);
    run_conv(16'h1234, 1'b0, 0, 19);
    run_conv(16'hFFFF, 1'b1, 0, 19);
    run_conv(16'h0000, 1'b1, 0, 19);
    run_conv(16'h8000, 1'b1, 0, 19);
    run_conv(16'h7FFF, 1'b1, 0, 19);
    run_conv(16'hB7E9, 1'b0, 5, 20);
    run_conv(16'hFFFF, 1'b0, 1, 20);
    run_conv(16'h5C3A, 1'b1, 16, 20);
    test_abort();
    run_conv(16'h0001, 1'b0, 0, 19);
    test_select_flip();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule